// File: doc/BRIEF.md
# Seven-Segment Scan Driver

This block lights four common-anode seven-segment displays that share one set of segment lines. Only one display is switched on at a time. The block steps through the positions fast enough that all four appear lit together. A free-running prescaler divides the system clock down to the scan step rate. A position sequencer walks the index 0, 1, 2, 3 and then wraps back to 0. A BCD decoder turns the selected digit into the segment pattern.

Position 0 shows the ones digit and position 1 shows the tens digit. Positions 2 and 3 are still scanned, but they receive an all-dark pattern. The digit enables and segment lines are active-low, and the decimal point is held dark. The default divide ratio of 100,000 gives a 1 kHz step rate from 100 MHz, which makes a 4 ms full refresh. The ratio is a parameter, so the step rate can be set anywhere in the 240 Hz to 4 kHz window the displays need.

Top module: `segscan_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge drives `digit_en_n` to 4'b1111, `seg_n` to 7'b1111111 and `dp_n` to 1, and resets the scan index so that position 0 is the first position shown after release.
- R2: From the first clock edge after reset is released, exactly one bit of `digit_en_n` is low in every cycle.
- R3: Bit k of `digit_en_n` low means position k is shown, and the shown position advances in the order 0, 1, 2, 3, 0, and so on.
- R4: Each position stays enabled for exactly `DIV_RATIO` consecutive clock cycles, including the first position after reset.
- R5: While position 1 is shown, `seg_n` carries the decoded `tens_bcd`. While position 0 is shown, it carries the decoded `ones_bcd`. In both cases the digit value is the one sampled at the clock edge that updates the outputs.
- R6: `seg_n[0]` through `seg_n[6]` drive segments a through g and are active-low. The codes 0–9 light these segments: 0=abcdef, 1=bc, 2=abdeg, 3=abcdg, 4=bcfg, 5=acdfg, 6=acdefg, 7=abc, 8=all seven, 9=abcdfg.
- R7: While position 2 or position 3 is shown, `seg_n` is 7'b1111111 whatever the digit inputs are.
- R8: A BCD code from 10 to 15 on a shown digit gives `seg_n` = 7'b1111111.
- R9: `dp_n` is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ones_bcd | input | 4 | BCD ones digit, shown at position 0 |
| tens_bcd | input | 4 | BCD tens digit, shown at position 1 |
| digit_en_n | output | 4 | Per-display enable, active low, bit k for position k |
| seg_n | output | 7 | Shared segment lines a..g in bits 0..6, active low |
| dp_n | output | 1 | Decimal point line, always 1 (dark) |

## Verification
The hardest case to reach from the ports is a digit code landing on a shown position at the exact edge the decoder uses. This matters most for the blank codes 10–15 and for a reset that arrives partway through a step at a blank position. The bench uses a short divide ratio. It changes both digit inputs on every cycle and sweeps all 256 code pairs twice, so every code meets positions 0 and 1 at several offsets within a step. It drops reset in the middle of a scan and then confirms that the next step starts at position 0 and lasts a full `DIV_RATIO` cycles.

// File: rtl/segscan_pkg.sv
// Package: shared constants and types for the seven-segment scan driver.
// Assumes: segment vectors hold a..g in bits 0..6, active low.
package segscan_pkg;

    localparam int SEG_W     = 7;
    localparam int BCD_W     = 4;
    localparam int SCAN_POS  = 4;

    typedef logic [SEG_W-1:0] seg_t;
    typedef logic [BCD_W-1:0] bcd_t;

    // All segments dark (active-low lines all high)
    localparam seg_t SEG_DARK = '1;

endpackage

// File: rtl/segscan_prescaler.sv
// Module: segscan_prescaler
// Purpose: free-running divider. It raises a one-cycle step pulse
//          once every DIV_RATIO clock cycles.
// Assumes: DIV_RATIO >= 2. The counter restarts from zero on reset.
module segscan_prescaler #(
    parameter int DIV_RATIO = 100000
) (
    input  logic clk,
    input  logic rst_n,
    output logic step
);

    localparam int CNT_W = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_RATIO - 1);

    logic [CNT_W-1:0] cnt_q;

    // Step pulse on the final count of each period
    always_comb begin
        step = (cnt_q == LAST);
    end

    // Count up and wrap to zero at the end of each period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/segscan_sequencer.sv
// Module: segscan_sequencer
// Purpose: holds the index of the position being scanned and moves it
//          on by one, wrapping, on each step pulse.
// Assumes: NUM_POS >= 2. Reset returns the index to position 0.
module segscan_sequencer #(
    parameter int NUM_POS = 4,
    localparam int POS_W  = (NUM_POS > 2) ? $clog2(NUM_POS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [POS_W-1:0] pos
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(NUM_POS - 1);

    logic [POS_W-1:0] pos_q;

    // Advance the scan index with wrap at the last position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (step) begin
            pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
        end
    end

    // Expose the index
    always_comb begin
        pos = pos_q;
    end

endmodule

// File: rtl/segscan_decoder.sv
// Module: segscan_decoder
// Purpose: turns a BCD code into active-low segment drive (a..g in
//          bits 0..6). Codes above 9 give a dark pattern.
// Assumes: purely combinational. The caller registers the result.
module segscan_decoder
    import segscan_pkg::*;
(
    input  bcd_t code,
    output seg_t seg_n
);

    seg_t lit;  // active-high segment set, bit order g..a

    // Pick which segments light for the code
    always_comb begin
        unique case (code)
            4'd0:    lit = 7'b011_1111;
            4'd1:    lit = 7'b000_0110;
            4'd2:    lit = 7'b101_1011;
            4'd3:    lit = 7'b100_1111;
            4'd4:    lit = 7'b110_0110;
            4'd5:    lit = 7'b110_1101;
            4'd6:    lit = 7'b111_1101;
            4'd7:    lit = 7'b000_0111;
            4'd8:    lit = 7'b111_1111;
            4'd9:    lit = 7'b110_1111;
            default: lit = 7'b000_0000;
        endcase
    end

    // Common-anode lines are active low
    always_comb begin
        seg_n = ~lit;
    end

endmodule

// File: rtl/segscan_top.sv
// Module: segscan_top
// Purpose: scans four common-anode displays on a shared segment bus.
//          Position 0 shows the ones digit, position 1 the tens digit,
//          and positions 2 and up are kept dark. All outputs are
//          registered.
// Assumes: synchronous active-low reset. Digit inputs are synchronous
//          to clk. DIV_RATIO sets the clock cycles per scan position.
module segscan_top
    import segscan_pkg::*;
#(
    parameter int DIV_RATIO = 100000,
    parameter int NUM_POS   = SCAN_POS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   ones_bcd,
    input  logic [3:0]   tens_bcd,
    output logic [3:0]   digit_en_n,
    output logic [6:0]   seg_n,
    output logic         dp_n
);

    localparam int POS_W = (NUM_POS > 2) ? $clog2(NUM_POS) : 1;

    logic             step;
    logic [POS_W-1:0] pos;
    bcd_t             pos_code [NUM_POS];
    logic             pos_live [NUM_POS];
    bcd_t             sel_code;
    logic             sel_live;
    seg_t             dec_seg_n;
    seg_t             seg_next;
    logic [NUM_POS-1:0] en_next;

    logic [NUM_POS-1:0] en_q;
    seg_t               seg_q;
    logic               dp_q;

    segscan_prescaler #(
        .DIV_RATIO (DIV_RATIO)
    ) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step)
    );

    segscan_sequencer #(
        .NUM_POS (NUM_POS)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .pos   (pos)
    );

    // Per-position source: which digit, and whether the position is shown
    generate
        for (genvar k = 0; k < NUM_POS; k++) begin : g_src
            if (k == 0) begin : g_ones
                always_comb begin
                    pos_code[k] = ones_bcd;
                    pos_live[k] = 1'b1;
                end
            end else if (k == 1) begin : g_tens
                always_comb begin
                    pos_code[k] = tens_bcd;
                    pos_live[k] = 1'b1;
                end
            end else begin : g_blank
                always_comb begin
                    pos_code[k] = '0;
                    pos_live[k] = 1'b0;
                end
            end
        end
    endgenerate

    // Select the source for the current scan position
    always_comb begin
        sel_code = pos_code[pos];
        sel_live = pos_live[pos];
    end

    segscan_decoder u_dec (
        .code  (sel_code),
        .seg_n (dec_seg_n)
    );

    // Blank positions override the decoder
    always_comb begin
        seg_next = sel_live ? dec_seg_n : SEG_DARK;
    end

    // One active-low enable per position, low only at the scan index
    generate
        for (genvar k = 0; k < NUM_POS; k++) begin : g_en
            always_comb begin
                en_next[k] = (pos != POS_W'(k));
            end
        end
    endgenerate

    // Output registers: all dark in reset, else follow the scan
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '1;
            seg_q <= SEG_DARK;
            dp_q  <= 1'b1;
        end else begin
            en_q  <= en_next;
            seg_q <= seg_next;
            dp_q  <= 1'b1;
        end
    end

    // Drive the pins
    always_comb begin
        digit_en_n = en_q[3:0];
        seg_n      = seg_q;
        dp_n       = dp_q;
    end

endmodule

// File: rtl/segscan_checker.sv
// Module: segscan_checker
// Purpose: clocked properties on the scan driver's ports, bound to
//          every segscan_top instance.
// Assumes: synchronous active-low reset on rst_n.
module segscan_checker (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] digit_en_n,
    input  logic [6:0] seg_n,
    input  logic       dp_n
);

    logic [3:0] prev_en;
    logic       prev_rst_n;

    // Remember last cycle's enables and reset level
    always_ff @(posedge clk) begin
        prev_en    <= digit_en_n;
        prev_rst_n <= rst_n;
    end

    // R1
    reset_dark_chk: assert property (@(posedge clk)
        !rst_n |=> (digit_en_n == 4'hF && seg_n == 7'h7F && dp_n));

    // R2
    one_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_rst_n && $past(rst_n)) |-> ($countones(~digit_en_n) == 1));

    // R3
    scan_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_rst_n && prev_en != 4'hF && digit_en_n != prev_en)
        |-> (digit_en_n == {prev_en[2:0], prev_en[3]}));

    // R7
    blank_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!digit_en_n[2] || !digit_en_n[3]) |-> (seg_n == 7'h7F));

    // R9
    dp_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prev_rst_n |-> dp_n);

endmodule

bind segscan_top segscan_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .digit_en_n (digit_en_n),
    .seg_n      (seg_n),
    .dp_n       (dp_n)
);

// File: tb/segscan_top_bench.sv
module segscan_top_bench;

    localparam int DIV = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ones_bcd = 4'd0;
    logic [3:0] tens_bcd = 4'd0;
    logic [3:0] digit_en_n;
    logic [6:0] seg_n;
    logic       dp_n;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // Reference model state
    int         m_cnt = 0;
    int         m_pos = 0;
    logic [3:0] exp_en = 4'hF;
    logic [6:0] exp_seg = 7'h7F;
    int         exp_code = 0;
    bit         m_live = 0;
    bit         m_started = 0;

    // Run-length tracking for R4
    int         run = 0;
    logic [3:0] last_en = 4'hF;

    always #5 clk = ~clk;

    segscan_top #(.DIV_RATIO(DIV)) u_segscan_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .ones_bcd   (ones_bcd),
        .tens_bcd   (tens_bcd),
        .digit_en_n (digit_en_n),
        .seg_n      (seg_n),
        .dp_n       (dp_n)
    );

    // Reference patterns, active low, bit order g..a
    function automatic logic [6:0] ref_seg(input int code);
        case (code)
            0: return 7'b100_0000;
            1: return 7'b111_1001;
            2: return 7'b010_0100;
            3: return 7'b011_0000;
            4: return 7'b001_1001;
            5: return 7'b001_0010;
            6: return 7'b000_0010;
            7: return 7'b111_1000;
            8: return 7'b000_0000;
            9: return 7'b001_0000;
            default: return 7'b111_1111;
        endcase
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural model advanced on each rising edge
    always @(posedge clk) begin
        m_started = 1;
        if (!rst_n) begin
            m_cnt = 0; m_pos = 0;
            exp_en = 4'hF; exp_seg = 7'h7F; m_live = 0;
        end else begin
            m_live = 1;
            exp_en = ~(4'b0001 << m_pos);
            if (m_pos == 0) begin exp_code = ones_bcd; exp_seg = ref_seg(ones_bcd); end
            else if (m_pos == 1) begin exp_code = tens_bcd; exp_seg = ref_seg(tens_bcd); end
            else begin exp_code = 0; exp_seg = 7'h7F; end
            if (m_cnt == DIV - 1) begin m_cnt = 0; m_pos = (m_pos + 1) % 4; end
            else m_cnt++;
        end
    end

    // Compare at the falling edge
    always @(negedge clk) begin
        if (m_started && !finished) begin
            if (!m_live) begin
                // R1 reset state
                check(digit_en_n == 4'hF && seg_n == 7'h7F && dp_n,
                      "R1", {3'b0, digit_en_n}, 7'h0F);
                run = 0;
            end else begin
                // R3 position order and enable mapping
                check(digit_en_n == exp_en, "R3", {3'b0, digit_en_n}, {3'b0, exp_en});
                // R2 single enable
                check($countones(~digit_en_n) == 1, "R2", {3'b0, digit_en_n}, {3'b0, exp_en});
                // R9 decimal point dark
                check(dp_n == 1'b1, "R9", {6'b0, dp_n}, 7'd1);
                if (exp_en[2] == 1'b0 || exp_en[3] == 1'b0)
                    check(seg_n == exp_seg, "R7", seg_n, exp_seg);
                else if (exp_code > 9)
                    check(seg_n == exp_seg, "R8", seg_n, exp_seg);
                else if (exp_en[1] == 1'b0)
                    check(seg_n == exp_seg, "R5", seg_n, exp_seg);
                else
                    check(seg_n == exp_seg, "R6", seg_n, exp_seg);
                // R4 step length
                if (run == 0) begin
                    run = 1; last_en = digit_en_n;
                end else if (digit_en_n != last_en) begin
                    check(run == DIV, "R4", 7'(run), 7'(DIV));
                    run = 1; last_en = digit_en_n;
                end else begin
                    run++;
                end
            end
        end
    end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
        end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        wait_cycles(3);
        rst_n = 1'b1;
        ones_bcd = 4'd3; tens_bcd = 4'd7;
        wait_cycles(40);
        // Sweep every code pair, changing every cycle
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                ones_bcd = 4'(b); tens_bcd = 4'(a);
                wait_cycles(1);
            end
        end
        // Reset in the middle of a scan
        while (digit_en_n != 4'b1011) wait_cycles(1);
        wait_cycles(2);
        rst_n = 1'b0;
        wait_cycles(2);
        rst_n = 1'b1;
        ones_bcd = 4'd9; tens_bcd = 4'd0;
        wait_cycles(60);
        // Second sweep with a different pairing
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                ones_bcd = 4'(15 - a); tens_bcd = 4'(b);
                wait_cycles(1);
            end
        end
        wait_cycles(30);
        finish_run();
    end

    // Watchdog
    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

endmodule